// File: doc/BRIEF.md
# Supply Fault Sequencer

This block turns three supply-monitor comparator flags into the ordered response a microcontroller core needs while its supply fails and recovers. The flags report that the supply is below the warning level, below the minimum operating level, and below the level where the system switches to its backup cell. The block synchronizes each flag and treats the three as nested: a backup trip implies a reset trip, and a reset trip implies a warning trip.

A warning trip produces a single interrupt request pulse when the warning interrupt is enabled, together with the fixed vector 2Bh. Code keeps running while only the warning level is crossed. A minimum-level trip, or a low driven onto the shared reset pin by another device, puts the core into reset and drives the open-drain reset pin low. Several devices can therefore hold one another in reset. A backup trip drives an active-low backup indication. When every reset cause clears, reset is held for a fixed power-on delay of 21,504 clocks before release.

Top module: `pwr_supervisor`

## Requirements
- R1: When the warning interrupt is enabled and the warning flag trips, `warn_irq` is high for exactly one clock, and `warn_vector` reads 8'h2B.
- R2: A warning excursion that begins while the interrupt is disabled produces no pulse. Enabling the interrupt later in the same excursion still produces none. The next pulse comes only after the warning flag has cleared and tripped again.
- R3: However long the warning flag stays tripped, it gives at most one pulse per excursion.
- R4: A warning trip on its own leaves `core_rst` low and `rst_pin_drive` low.
- R5: A minimum-level trip raises `core_rst` and `rst_pin_drive` within three clocks. While reset is asserted the pin is always driven.
- R6: An external low on `rst_pin_in` while the block is not driving the pin forces `core_rst` high within three clocks. Release then follows 21,504 clocks after the block first sees that low.
- R7: A backup trip drives `bkp_n` low within three clocks and forces reset even when the other two flags are clear. `bkp_n` is never low while `core_rst` is low.
- R8: After the last reset cause clears at the input, `core_rst` falls on exactly the 21,506th rising clock edge: two synchronizer edges plus 21,504 delay edges.
- R9: When the warning and minimum-level flags trip in the same clock, no interrupt pulse is issued, and `warn_irq` is never high while `core_rst` is high.
- R10: After `rst_n` is released, `core_rst` and `rst_pin_drive` stay high for 21,504 clocks, `bkp_n` is high and `warn_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warn_trip | input | 1 | Comparator: supply below the warning level |
| min_trip | input | 1 | Comparator: supply below the minimum operating level |
| bkp_trip | input | 1 | Comparator: supply below the backup switchover level |
| warn_irq_en | input | 1 | Enable for the warning interrupt |
| rst_pin_in | input | 1 | Level read back from the shared open-drain reset pin |
| warn_irq | output | 1 | One-clock warning interrupt request |
| warn_vector | output | 8 | Interrupt vector for the warning request (2Bh) |
| core_rst | output | 1 | Internal reset to the core, active high |
| rst_pin_drive | output | 1 | Pull the reset pin low when 1 |
| bkp_n | output | 1 | Low while running from the backup cell |

## Verification
Two functions can land in the same clock: the warning interrupt and reset entry. A fast supply collapse trips the warning and minimum-level flags together. The bench provokes this by raising both comparator inputs on one clock. It judges the result by checking that no interrupt pulse appears in the following window while `core_rst` rises on schedule. A second overlap happens on the shared reset pin, where the block's own drive and an external pull meet. The bench models the pin as a wired-AND, pulls it externally, and checks that the release falls exactly one delay period after the block first sees the external low.

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int          SYNC_STAGES = 2,
  parameter int          POR_CYCLES  = 21504,
  parameter logic [7:0]  VECTOR      = 8'h2B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       warn_trip,
  input  logic       min_trip,
  input  logic       bkp_trip,
  input  logic       warn_irq_en,
  input  logic       rst_pin_in,
  output logic       warn_irq,
  output logic [7:0] warn_vector,
  output logic       core_rst,
  output logic       rst_pin_drive,
  output logic       bkp_n
);
  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYCLES);

  logic [SYNC_STAGES-1:0] sy_w, sy_m, sy_b, sy_p;
  logic [SYNC_STAGES-1:0] drv_hist;
  logic [CW-1:0]          hold_cnt;
  logic                   armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_w <= '0;
      sy_m <= '0;
      sy_b <= '0;
      sy_p <= '1;
    end else begin
      sy_w <= {sy_w[SYNC_STAGES-2:0], warn_trip};
      sy_m <= {sy_m[SYNC_STAGES-2:0], min_trip};
      sy_b <= {sy_b[SYNC_STAGES-2:0], bkp_trip};
      sy_p <= {sy_p[SYNC_STAGES-2:0], rst_pin_in};
    end
  end

  wire lvl_bkp  = sy_b[SYNC_STAGES-1];
  wire lvl_min  = sy_m[SYNC_STAGES-1] | lvl_bkp;
  wire lvl_warn = sy_w[SYNC_STAGES-1] | lvl_min;

  wire self_drv = rst_pin_drive | (|drv_hist);
  wire ext_low  = ~sy_p[SYNC_STAGES-1] & ~self_drv;
  wire rst_cause = lvl_min | ext_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= POR_LOAD;
      drv_hist <= '1;
    end else begin
      drv_hist <= {drv_hist[SYNC_STAGES-2:0], rst_pin_drive};
      if (rst_cause)
        hold_cnt <= POR_LOAD;
      else if (hold_cnt != '0)
        hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign core_rst      = (hold_cnt != '0);
  assign rst_pin_drive = core_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b1;
      warn_irq <= 1'b0;
      bkp_n    <= 1'b1;
    end else begin
      bkp_n    <= ~lvl_bkp;
      warn_irq <= lvl_warn & armed & warn_irq_en & ~core_rst & ~rst_cause;
      if (!lvl_warn)
        armed <= 1'b1;
      else
        armed <= 1'b0;
    end
  end

  assign warn_vector = VECTOR;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       warn_irq_en,
  input logic       warn_irq,
  input logic [7:0] warn_vector,
  input logic       core_rst,
  input logic       rst_pin_drive,
  input logic       bkp_n
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |=> !warn_irq); // R3
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> warn_vector == 8'h2B); // R1
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_irq) |-> $past(warn_irq_en)); // R2
  AST_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> rst_pin_drive); // R5
  AST_BKP_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !bkp_n |-> core_rst); // R7
  AST_NO_IRQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> !core_rst); // R9
endmodule

bind pwr_supervisor pwr_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .warn_irq_en(warn_irq_en), .warn_irq(warn_irq),
  .warn_vector(warn_vector), .core_rst(core_rst),
  .rst_pin_drive(rst_pin_drive), .bkp_n(bkp_n)
);

// File: tb/sim_pwr_supervisor.sv
`timescale 1ns/1ps
module sim_pwr_supervisor;
  localparam int POR = 21504;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warn_trip = 1'b0, min_trip = 1'b0, bkp_trip = 1'b0;
  logic warn_irq_en = 1'b0, ext_pull = 1'b0;
  logic warn_irq, core_rst, rst_pin_drive, bkp_n;
  logic [7:0] warn_vector;
  wire rst_pin = ~(rst_pin_drive | ext_pull);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .warn_trip(warn_trip), .min_trip(min_trip),
    .bkp_trip(bkp_trip), .warn_irq_en(warn_irq_en), .rst_pin_in(rst_pin),
    .warn_irq(warn_irq), .warn_vector(warn_vector), .core_rst(core_rst),
    .rst_pin_drive(rst_pin_drive), .bkp_n(bkp_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_pulses(input int win, output int n);
    n = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (warn_irq) n++;
    end
  endtask

  task automatic edges_to_release(output int n);
    n = 0;
    while (core_rst && n < POR + 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_power_on;
    int n;
    @(negedge clk);
    chk(core_rst == 1, "R10 core_rst at reset", core_rst, 1);
    chk(rst_pin_drive == 1, "R10 pin drive at reset", rst_pin_drive, 1);
    chk(bkp_n == 1, "R10 bkp_n at reset", bkp_n, 1);
    chk(warn_irq == 0, "R10 irq at reset", warn_irq, 0);
    rst_n = 1'b1;
    edges_to_release(n);
    chk(n == POR, "R10 power-on delay", n, POR);
    chk(rst_pin_drive == 0, "R10 pin released", rst_pin_drive, 0);
  endtask

  task automatic t_warn_enabled;
    int n;
    warn_irq_en = 1'b1;
    warn_trip = 1'b1;
    step(2);
    @(posedge clk); @(negedge clk);
    chk(warn_irq == 1, "R1 pulse on third edge", warn_irq, 1);
    chk(warn_vector == 8'h2B, "R1 vector", warn_vector, 8'h2B);
    count_pulses(30, n);
    chk(n == 0, "R3 single pulse per excursion", n, 0);
    chk(core_rst == 0, "R4 warning keeps core running", core_rst, 0);
    chk(rst_pin_drive == 0, "R4 pin not driven", rst_pin_drive, 0);
    warn_trip = 1'b0;
    step(5);
    warn_trip = 1'b1;
    count_pulses(8, n);
    chk(n == 1, "R3 re-armed after clearing", n, 1);
    warn_trip = 1'b0;
    step(5);
  endtask

  task automatic t_warn_disabled;
    int n;
    warn_irq_en = 1'b0;
    warn_trip = 1'b1;
    count_pulses(8, n);
    chk(n == 0, "R2 disabled gives no pulse", n, 0);
    warn_irq_en = 1'b1;
    count_pulses(8, n);
    chk(n == 0, "R2 late enable same excursion", n, 0);
    warn_trip = 1'b0;
    step(5);
    warn_trip = 1'b1;
    count_pulses(8, n);
    chk(n == 1, "R2 next excursion pulses", n, 1);
    warn_trip = 1'b0;
    step(5);
  endtask

  task automatic t_min_reset;
    int n;
    min_trip = 1'b1;
    step(3);
    chk(core_rst == 1, "R5 min trip resets", core_rst, 1);
    chk(rst_pin_drive == 1, "R5 pin driven", rst_pin_drive, 1);
    step(20);
    min_trip = 1'b0;
    edges_to_release(n);
    chk(n == POR + 2, "R8 release edge count", n, POR + 2);
  endtask

  task automatic t_same_cycle;
    int n;
    warn_irq_en = 1'b1;
    warn_trip = 1'b1;
    min_trip = 1'b1;
    count_pulses(10, n);
    chk(n == 0, "R9 no pulse on joint trip", n, 0);
    chk(core_rst == 1, "R9 reset taken", core_rst, 1);
    warn_trip = 1'b0;
    min_trip = 1'b0;
    edges_to_release(n);
    chk(n == POR + 2, "R8 release after joint trip", n, POR + 2);
    step(5);
  endtask

  task automatic t_ext_pin;
    int n;
    ext_pull = 1'b1;
    step(3);
    chk(core_rst == 1, "R6 external low resets", core_rst, 1);
    step(7);
    ext_pull = 1'b0;
    edges_to_release(n);
    chk(n == POR + 3 - 10, "R6 release after external low", n, POR - 7);
    step(10);
    chk(core_rst == 0, "R6 no self re-trigger", core_rst, 0);
  endtask

  task automatic t_backup;
    int n;
    bkp_trip = 1'b1;
    step(3);
    chk(bkp_n == 0, "R7 backup indication", bkp_n, 0);
    chk(core_rst == 1, "R7 backup implies reset", core_rst, 1);
    bkp_trip = 1'b0;
    step(3);
    chk(bkp_n == 1, "R7 backup cleared", bkp_n, 1);
    edges_to_release(n);
    chk(n == POR + 2 - 3, "R8 release after backup", n, POR - 1);
  endtask

  initial begin
    t_power_on();
    t_warn_enabled();
    t_warn_disabled();
    t_min_reset();
    t_same_cycle();
    t_ext_pin();
    t_backup();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule